// File: doc/BRIEF.md
# CCM Block-Pair Formatter

This block prepares the per-block operands for an iterative CCM engine with fixed parameters: an 8-byte tag and a 2-byte length and counter field. A frame starts with a one-cycle start pulse that carries a 13-byte nonce and the payload length in bytes. The nonce is built from a priority octet, a 48-bit transmitter address and a 48-bit packet number, in that order and most significant byte first. From these the block presents the authentication seed block B0 and the tag-masking counter block A0 together, one cycle after the start.

After the header, the payload arrives as a 16-bit beat stream under a valid/ready handshake. Each group of eight beats becomes one 128-bit block. Bytes past the frame length are forced to zero, and padding beats are produced internally without drawing on the stream. Each payload block is emitted together with its counter block. Emission is paced to a ten-cycle cipher slot: the next block is gathered while the previous one is being ciphered, so only the header costs an extra load cycle.

Top module: `ccm_blk_fmt`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, hdr_vld_o, blk_vld_o and beat_rdy_o are low.
- R2: A start_i sampled while idle makes hdr_vld_o high for exactly the next cycle. In that cycle b0_o = {8'h59, nonce, len}, where nonce = {prio_i, ta_i, pn_i} (104 bits, MSB first) and len = len_i, all captured at the start.
- R3: While hdr_vld_o is high, a0_o = {8'h01, nonce, 16'h0000}.
- R4: A frame of len bytes produces exactly Q = ceil(len/16) blk_vld_o pulses. A frame with len 0 produces only the header.
- R5: blk_o holds 16 bytes in arrival order with the first byte in bits 127:120. Within a beat, beat_i[15:8] is the earlier byte.
- R6: Block bytes at or beyond len are zero, including the low byte of a final odd-length beat. beat_rdy_o stays low once all len bytes have been accepted.
- R7: The k-th payload block (k = 1..Q) is accompanied by ctr_o = {8'h01, nonce, k as 16 bits}.
- R8: hdr_vld_o and blk_vld_o never coincide. Successive pulses of either are at least 10 cycles apart. When a beat is offered every cycle, the spacing is exactly 10.
- R9: A beat is taken only on a cycle with beat_vld_i and beat_rdy_o both high. beat_rdy_o is low while the header or a block is presented. A late beat delays the block but does not corrupt it.
- R10: start_i is ignored while a frame is in progress. The nonce used for counter blocks and a0_o stays unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start, honoured only when idle |
| prio_i | input | 8 | Priority octet of the nonce |
| ta_i | input | 48 | Transmitter address of the nonce |
| pn_i | input | 48 | Packet number of the nonce |
| len_i | input | 16 | Payload length in bytes |
| beat_vld_i | input | 1 | Payload beat offered |
| beat_i | input | 16 | Payload beat, earlier byte in the high half |
| beat_rdy_o | output | 1 | Beat accepted this cycle if offered |
| hdr_vld_o | output | 1 | B0 and A0 valid |
| b0_o | output | 128 | Authentication seed block |
| a0_o | output | 128 | Tag-masking counter block |
| blk_vld_o | output | 1 | Payload block and counter block valid |
| blk_o | output | 128 | Zero-padded payload block |
| ctr_o | output | 128 | Counter block for the current payload block |

## Verification
The assertions check the following on every cycle:
- The header strobe lasts one cycle and follows a start.
- B0 and A0 share the nonce, and A0 carries a zero counter.
- Each counter block repeats A0's flags and nonce, and its counter rises from 1 after each header.
- The two strobes never overlap and keep a ten-cycle minimum gap.
- The stream is never ready while an output is presented.
- A0 changes only at a header, so a mid-frame start cannot alter the nonce.

Only the bench scenarios can show the following:
- The block contents, including byte order and zero padding for odd and partial lengths.
- The exact number of blocks per frame.
- The exact ten-cycle spacing under a full-rate stream.
- The delay and data integrity under random stalls.

// File: rtl/ccm_fmt_pkg.sv
package ccm_fmt_pkg;
  localparam int unsigned BLK_W   = 128;
  localparam int unsigned NONCE_W = 104;
  localparam int unsigned LEN_W   = 16;           // L = 2 bytes
  localparam int unsigned Q_W     = LEN_W - 3;    // ceil(len/16) fits
  localparam logic [7:0]  B0_FLAGS  = 8'h59;      // adata, (M-2)/2=3, L-1=1
  localparam logic [7:0]  CTR_FLAGS = 8'h01;      // L-1

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_SLOT, ST_EMIT} fmt_st_e;
endpackage

// File: rtl/ccm_beat_packer.sv
module ccm_beat_packer
  import ccm_fmt_pkg::*;
#(
  parameter int unsigned BEAT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                gather_i,
  input  logic                clr_i,
  input  logic                beat_vld_i,
  input  logic [BEAT_W-1:0]   beat_i,
  output logic                beat_rdy_o,
  output logic                full_o,
  output logic [BLK_W-1:0]    blk_o
);
  localparam int unsigned BPB   = BEAT_W / 8;
  localparam int unsigned BEATS = BLK_W / BEAT_W;
  localparam int unsigned CNT_W = $clog2(BEATS + 1);

  logic [CNT_W-1:0]  beat_q;
  logic [LEN_W-1:0]  rem_q, rem_nxt;
  logic [BLK_W-1:0]  blk_q;
  logic [BEAT_W-1:0] beat_w;
  logic              pad_only, step;

  assign full_o     = (beat_q == CNT_W'(BEATS));
  assign pad_only   = (rem_q == '0);
  assign beat_rdy_o = gather_i && !full_o && !pad_only;
  // padding beats advance without touching the stream
  assign step       = gather_i && !full_o && (pad_only || beat_vld_i);
  assign rem_nxt    = (rem_q > LEN_W'(BPB)) ? rem_q - LEN_W'(BPB) : '0;

  always_comb begin
    for (int b = 0; b < BPB; b++) begin
      beat_w[BEAT_W-1-8*b -: 8] = (rem_q > LEN_W'(b)) ? beat_i[BEAT_W-1-8*b -: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      rem_q  <= '0;
      blk_q  <= '0;
    end else if (load_i) begin
      beat_q <= '0;
      rem_q  <= len_i;
    end else if (clr_i) begin
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_q + 1'b1;
      rem_q  <= rem_nxt;
      blk_q  <= {blk_q[BLK_W-BEAT_W-1:0], beat_w};
    end
  end

  assign blk_o = blk_q;
endmodule

// File: rtl/ccm_slot_ctrl.sv
module ccm_slot_ctrl
  import ccm_fmt_pkg::*;
#(
  parameter int unsigned SLOT_CYC = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [Q_W-1:0]   q_i,
  input  logic             full_i,
  output fmt_st_e          state_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic             load_o
);
  localparam int unsigned TMR_W    = $clog2(SLOT_CYC);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SLOT_CYC - 2); // gather cycles minus one

  fmt_st_e          st_q;
  logic [TMR_W-1:0] tmr_q;
  logic [LEN_W-1:0] cnt_q;
  logic [Q_W-1:0]   q_q;

  assign load_o = (st_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      cnt_q <= '0;
      q_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          q_q   <= q_i;
          cnt_q <= LEN_W'(1);
          st_q  <= ST_HDR;
        end
        ST_HDR: begin
          tmr_q <= '0;
          st_q  <= (q_q == '0) ? ST_IDLE : ST_SLOT;
        end
        ST_SLOT: begin
          if (tmr_q != TMR_LAST) tmr_q <= tmr_q + 1'b1;
          else if (full_i)       st_q  <= ST_EMIT;
        end
        ST_EMIT: begin
          tmr_q <= '0;
          if (cnt_q == LEN_W'(q_q)) st_q <= ST_IDLE;
          else begin
            cnt_q <= cnt_q + 1'b1;
            st_q  <= ST_SLOT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ccm_blk_fmt.sv
module ccm_blk_fmt
  import ccm_fmt_pkg::*;
#(
  parameter int unsigned BEAT_W   = 16,
  parameter int unsigned SLOT_CYC = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        prio_i,
  input  logic [47:0]       ta_i,
  input  logic [47:0]       pn_i,
  input  logic [15:0]       len_i,
  input  logic              beat_vld_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic              beat_rdy_o,
  output logic              hdr_vld_o,
  output logic [127:0]      b0_o,
  output logic [127:0]      a0_o,
  output logic              blk_vld_o,
  output logic [127:0]      blk_o,
  output logic [127:0]      ctr_o
);
  fmt_st_e            st;
  logic [LEN_W-1:0]   cnt;
  logic               load, full;
  logic [LEN_W:0]     len_rnd;
  logic [Q_W-1:0]     q_w;
  logic [NONCE_W-1:0] nonce_q;
  logic [LEN_W-1:0]   len_q;

  assign len_rnd = {1'b0, len_i} + (LEN_W+1)'(15);
  assign q_w     = len_rnd[LEN_W:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nonce_q <= '0;
      len_q   <= '0;
    end else if (load) begin
      nonce_q <= {prio_i, ta_i, pn_i};
      len_q   <= len_i;
    end
  end

  ccm_slot_ctrl #(.SLOT_CYC(SLOT_CYC)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .q_i     (q_w),
    .full_i  (full),
    .state_o (st),
    .cnt_o   (cnt),
    .load_o  (load)
  );

  ccm_beat_packer #(.BEAT_W(BEAT_W)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .len_i      (len_i),
    .gather_i   (st == ST_SLOT),
    .clr_i      (st == ST_EMIT),
    .beat_vld_i (beat_vld_i),
    .beat_i     (beat_i),
    .beat_rdy_o (beat_rdy_o),
    .full_o     (full),
    .blk_o      (blk_o)
  );

  assign hdr_vld_o = (st == ST_HDR);
  assign blk_vld_o = (st == ST_EMIT);
  assign b0_o      = {B0_FLAGS, nonce_q, len_q};
  assign a0_o      = {CTR_FLAGS, nonce_q, 16'h0000};
  assign ctr_o     = {CTR_FLAGS, nonce_q, cnt};
endmodule

// File: rtl/ccm_blk_fmt_chk.sv
module ccm_blk_fmt_chk #(
  parameter int unsigned BEAT_W   = 16,
  parameter int unsigned SLOT_CYC = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              beat_rdy_o,
  input logic              hdr_vld_o,
  input logic [127:0]      b0_o,
  input logic [127:0]      a0_o,
  input logic              blk_vld_o,
  input logic [127:0]      ctr_o
);
  localparam int unsigned GAP_W = $clog2(SLOT_CYC + 1);

  logic [GAP_W-1:0] gap_q;
  logic [15:0]      exp_ctr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= GAP_W'(SLOT_CYC);
      exp_ctr_q <= 16'd1;
    end else begin
      if (hdr_vld_o || blk_vld_o)   gap_q <= GAP_W'(1);
      else if (gap_q < GAP_W'(SLOT_CYC)) gap_q <= gap_q + 1'b1;
      if (hdr_vld_o)      exp_ctr_q <= 16'd1;
      else if (blk_vld_o) exp_ctr_q <= exp_ctr_q + 16'd1;
    end
  end

  AST_HDR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) hdr_vld_o |=> !hdr_vld_o); // R2
  AST_HDR_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(hdr_vld_o) |-> $past(start_i)); // R2
  AST_A0_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_vld_o |-> (a0_o[15:0] == 16'h0 && a0_o[127:120] == 8'h01 && b0_o[119:16] == a0_o[119:16])); // R3
  AST_CTR_NONCE: assert property (@(posedge clk_i) disable iff (!rst_ni) blk_vld_o |-> ctr_o[127:16] == a0_o[127:16]); // R7
  AST_CTR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni) blk_vld_o |-> ctr_o[15:0] == exp_ctr_q); // R7
  AST_SLOT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni) blk_vld_o |-> gap_q >= GAP_W'(SLOT_CYC)); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni) !(hdr_vld_o && blk_vld_o)); // R8
  AST_RDY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) (hdr_vld_o || blk_vld_o) |-> !beat_rdy_o); // R9
  AST_NONCE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(a0_o) |-> hdr_vld_o); // R10
endmodule

bind ccm_blk_fmt ccm_blk_fmt_chk #(.BEAT_W(BEAT_W), .SLOT_CYC(SLOT_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .beat_rdy_o (beat_rdy_o),
  .hdr_vld_o  (hdr_vld_o),
  .b0_o       (b0_o),
  .a0_o       (a0_o),
  .blk_vld_o  (blk_vld_o),
  .ctr_o      (ctr_o)
);

// File: tb/sim_ccm_blk_fmt.sv
`timescale 1ns/1ps
module sim_ccm_blk_fmt;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [7:0]   prio_i = '0;
  logic [47:0]  ta_i = '0;
  logic [47:0]  pn_i = '0;
  logic [15:0]  len_i = '0;
  logic         beat_vld_i = 1'b0;
  logic [15:0]  beat_i = '0;
  logic         beat_rdy_o, hdr_vld_o, blk_vld_o;
  logic [127:0] b0_o, a0_o, blk_o, ctr_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pay [0:511];

  always #2.5 clk_i = ~clk_i;

  ccm_blk_fmt u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_blk(input int k, input int len);
    logic [127:0] v = '0;
    for (int i = 0; i < 16; i++) begin
      int idx = 16*(k-1) + i;
      v[127-8*i -: 8] = (idx < len) ? pay[idx] : 8'h00;
    end
    return v;
  endfunction

  task automatic run_frame(input int len, input bit stall, input bit poke);
    int q, seen, last, p, cyc, tail;
    bit extra_hdr, late_rdy, acc;
    logic [103:0] nonce;
    logic [7:0] lo, hi;
    q = (len + 15) / 16;
    for (int i = 0; i < 512; i++) pay[i] = 8'($urandom);
    @(negedge clk_i);
    prio_i = 8'($urandom); ta_i = {16'($urandom), 32'($urandom)};
    pn_i = {16'($urandom), 32'($urandom)}; len_i = 16'(len);
    nonce = {prio_i, ta_i, pn_i};
    start_i = 1'b1; beat_vld_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    prio_i = 8'($urandom); pn_i = {16'($urandom), 32'($urandom)}; len_i = 16'($urandom);
    chk(hdr_vld_o === 1'b1, "R2 header strobe", 128'(hdr_vld_o), 128'd1);
    chk(b0_o === {8'h59, nonce, 16'(len)}, "R2 b0 layout", b0_o, {8'h59, nonce, 16'(len)});
    chk(a0_o === {8'h01, nonce, 16'h0}, "R3 a0 layout", a0_o, {8'h01, nonce, 16'h0});
    seen = 0; last = 0; p = 0; cyc = 0; tail = 0;
    extra_hdr = 0; late_rdy = 0;
    while (tail < 12 && cyc < 40*q + 60) begin
      // drive next cycle's inputs
      beat_vld_i = stall ? ($urandom % 3 != 0) : 1'b1;
      hi = (p < len) ? pay[p] : 8'($urandom);
      lo = (p + 1 < len) ? pay[p+1] : 8'($urandom);
      beat_i = {hi, lo};
      start_i = poke && (cyc == 5);
      if (start_i) begin prio_i = ~nonce[103:96]; len_i = 16'd40; end
      if (beat_rdy_o && p >= len) late_rdy = 1;
      acc = beat_vld_i && beat_rdy_o;
      @(negedge clk_i);
      cyc++;
      if (acc) p += 2;
      if (hdr_vld_o) extra_hdr = 1;
      if (blk_vld_o) begin
        seen++;
        chk(blk_o === exp_blk(seen, len), "R5 R6 block content", blk_o, exp_blk(seen, len));
        chk(ctr_o === {8'h01, nonce, 16'(seen)}, "R7 counter block", ctr_o, {8'h01, nonce, 16'(seen)});
        chk(cyc - last >= 10, "R8 min spacing", 128'(cyc - last), 128'd10);
        if (!stall) chk(cyc - last == 10, "R8 full-rate spacing", 128'(cyc - last), 128'd10);
        last = cyc;
      end
      if (seen >= q) tail++;
    end
    start_i = 1'b0; beat_vld_i = 1'b0;
    chk(seen == q, "R4 block count", 128'(seen), 128'(q));
    chk(!extra_hdr, "R10 start ignored mid-frame", 128'(extra_hdr), 128'd0);
    chk(!late_rdy, "R6 no ready after payload", 128'(late_rdy), 128'd0);
    chk(beat_rdy_o === 1'b0, "R9 idle not ready", 128'(beat_rdy_o), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk({hdr_vld_o, blk_vld_o, beat_rdy_o} === 3'b000, "R1 in reset", 128'({hdr_vld_o, blk_vld_o, beat_rdy_o}), 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({hdr_vld_o, blk_vld_o, beat_rdy_o} === 3'b000, "R1 after reset", 128'({hdr_vld_o, blk_vld_o, beat_rdy_o}), 128'd0);
    run_frame(0, 0, 0);     // R4 header only
    run_frame(1, 0, 0);     // R6 single byte
    run_frame(16, 0, 0);    // exact block
    run_frame(17, 0, 0);    // one byte spills
    run_frame(31, 1, 0);    // R6 odd tail with stalls
    run_frame(64, 0, 1);    // R10 poke mid-frame
    run_frame(48, 1, 1);    // R9 stalls plus poke
    for (int f = 0; f < 20; f++)
      run_frame(int'($urandom % 201), bit'($urandom % 2), bit'(f % 4 == 0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule